// File: doc/BRIEF.md
# Pipeline Overflow Trap Controller

This block is the trap control for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It takes the execute stage's instruction class, valid bit, program counter and signed-overflow flag. A trap is taken when a valid signed add or subtract overflows.

In the cycle that the execute stage detects the trap, the block does four things. It steers the next fetch address to a fixed handler vector. It flushes the fetch, decode and execute pipeline registers. It clears the writeback controls of the faulting instruction as that instruction moves into the memory stage. At the clock edge that closes the same cycle, it loads the return address and a cause code into their holding registers.

The handler is fetched in the cycle right after detection, so no bubble is spent on the redirect. When there is no trap, the block passes a taken-branch target or the sequential address through to the fetch stage.

Top module: `ovf_trap_ctrl`

## Requirements
- R1: `trap_taken` is high in the same cycle when `ex_valid` is 1, `ex_ovf` is 1 and `ex_op` is 1 (signed add) or 2 (signed subtract).
- R2: In a trap cycle, `next_pc` is 0x50000150 and `pc_sel` is 2.
- R3: After a trap cycle, `epc` holds the execute-stage PC of that cycle plus 4. For example, a fault at 0x5C leaves 0x60.
- R4: `flush_if`, `flush_id`, `flush_ex` and `squash_wb` are all high in a trap cycle and all low in every other cycle.
- R5: After a trap cycle, `cause` holds the overflow code 12.
- R6: No trap is taken for an unsigned add (`ex_op` = 3), an unsigned subtract (4) or any other opcode (0, 5, 6, 7). No trap is taken when `ex_valid` is 0, even if `ex_ovf` is 1.
- R7: Take one fetch per cycle from cycle 1 at 0x50, with each instruction in execute two cycles after its fetch. Then an overflowing add fetched in cycle 4 drives `next_pc` to the vector in cycle 6, so the handler is fetched in cycle 7.
- R8: A trap wins over a taken branch in the same cycle. Without a trap, a taken branch gives `pc_sel` 1 and `next_pc` = `br_target`. Otherwise `pc_sel` is 0 and `next_pc` = `seq_pc`.
- R9: `epc` and `cause` reset to 0 and keep their values through every cycle in which no trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_ovf | input | 1 | Signed overflow flag from the execute ALU |
| ex_op | input | 3 | Execute-stage arithmetic class (encoding given in R1 and R6) |
| ex_pc | input | 32 | Address of the execute-stage instruction |
| br_taken | input | 1 | Branch redirect request |
| br_target | input | 32 | Branch target address |
| seq_pc | input | 32 | Sequential fetch address |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 trap |
| next_pc | output | 32 | Address of the next fetch |
| flush_if | output | 1 | Clear the fetch/decode register |
| flush_id | output | 1 | Clear the decode/execute register |
| flush_ex | output | 1 | Clear the execute-stage instruction |
| squash_wb | output | 1 | Zero the writeback controls entering memory |
| trap_taken | output | 1 | A trap is being taken this cycle |
| epc | output | 32 | Saved return address |
| cause | output | 5 | Saved trap cause code |

## Verification
The assertions assume that `ex_op`, `ex_ovf` and `ex_valid` are stable for the whole cycle and are only valid as a group. They also assume that `ex_pc` is word aligned and far enough below the top of the address space that adding 4 does not wrap.

The stimulus is driven at the falling edge with aligned addresses in a low range, so every sample sees settled inputs. It pairs the overflow flag with every opcode value and with `ex_valid` low. It never presents a trap in two back-to-back cycles, except in one directed case that checks the second capture replaces the first.

// File: rtl/ovf_trap_pkg.sv
package ovf_trap_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_ADDU = 3'd3,
    OP_SUBU = 3'd4
  } arith_op_e;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_TRAP   = 2'd2
  } pc_src_e;

  // Opcodes whose signed overflow must trap.
  function automatic logic op_traps(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  // Return address saved for a faulting instruction.
  function automatic logic [31:0] return_addr(input logic [31:0] pc);
    return pc + 32'd4;
  endfunction

endpackage

// File: rtl/trap_detect.sv
module trap_detect
  import ovf_trap_pkg::*;
(
  input  logic       ex_valid,
  input  logic       ex_ovf,
  input  logic [2:0] ex_op,
  output logic       trap_fire
);
  logic op_is_signed;

  always_comb begin
    op_is_signed = op_traps(ex_op);
    trap_fire    = ex_valid && ex_ovf && op_is_signed;
  end
endmodule

// File: rtl/redirect_mux.sv
module redirect_mux
  import ovf_trap_pkg::*;
#(
  parameter int          XLEN   = 32,
  parameter logic [31:0] VECTOR = 32'h5000_0150
) (
  input  logic            trap_fire,
  input  logic            br_taken,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] seq_pc,
  output logic [1:0]      pc_sel,
  output logic [XLEN-1:0] next_pc
);
  localparam logic [XLEN-1:0] VEC_X = XLEN'(VECTOR);

  always_comb begin
    // Trap has the highest priority, then branch, then sequential.
    if (trap_fire) begin
      pc_sel  = SEL_TRAP;
      next_pc = VEC_X;
    end else if (br_taken) begin
      pc_sel  = SEL_BRANCH;
      next_pc = br_target;
    end else begin
      pc_sel  = SEL_SEQ;
      next_pc = seq_pc;
    end
  end
endmodule

// File: rtl/trap_state.sv
module trap_state
  import ovf_trap_pkg::*;
#(
  parameter int             XLEN      = 32,
  parameter int             CW        = 5,
  parameter logic [CW-1:0]  CAUSE_OVF = 5'd12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_fire,
  input  logic [XLEN-1:0] ex_pc,
  output logic [XLEN-1:0] epc,
  output logic [CW-1:0]   cause
);
  logic [XLEN-1:0] ret_addr;

  always_comb begin
    ret_addr = XLEN'(return_addr(32'(ex_pc)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else if (trap_fire) begin
      epc   <= ret_addr;
      cause <= CAUSE_OVF;
    end
  end
endmodule

// File: rtl/ovf_trap_ctrl.sv
module ovf_trap_ctrl
  import ovf_trap_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CW        = 5,
  parameter logic [31:0] VECTOR    = 32'h5000_0150,
  parameter logic [4:0]  CAUSE_OVF = 5'd12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_valid,
  input  logic            ex_ovf,
  input  logic [2:0]      ex_op,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            br_taken,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] seq_pc,
  output logic [1:0]      pc_sel,
  output logic [XLEN-1:0] next_pc,
  output logic            flush_if,
  output logic            flush_id,
  output logic            flush_ex,
  output logic            squash_wb,
  output logic            trap_taken,
  output logic [XLEN-1:0] epc,
  output logic [CW-1:0]   cause
);
  // Flush lines: fetch, decode, execute, and writeback-control squash.
  localparam int NFLUSH = 4;

  logic              trap_fire;
  logic [NFLUSH-1:0] flush_vec;

  trap_detect u_detect (
    .ex_valid (ex_valid),
    .ex_ovf   (ex_ovf),
    .ex_op    (ex_op),
    .trap_fire(trap_fire)
  );

  redirect_mux #(.XLEN(XLEN), .VECTOR(VECTOR)) u_mux (
    .trap_fire(trap_fire),
    .br_taken (br_taken),
    .br_target(br_target),
    .seq_pc   (seq_pc),
    .pc_sel   (pc_sel),
    .next_pc  (next_pc)
  );

  trap_state #(.XLEN(XLEN), .CW(CW), .CAUSE_OVF(CW'(CAUSE_OVF))) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_fire(trap_fire),
    .ex_pc    (ex_pc),
    .epc      (epc),
    .cause    (cause)
  );

  for (genvar g = 0; g < NFLUSH; g++) begin : g_flush
    assign flush_vec[g] = trap_fire;
  end

  assign flush_if   = flush_vec[0];
  assign flush_id   = flush_vec[1];
  assign flush_ex   = flush_vec[2];
  assign squash_wb  = flush_vec[3];
  assign trap_taken = trap_fire;
endmodule

// File: rtl/ovf_trap_chk.sv
module ovf_trap_chk #(
  parameter int          XLEN   = 32,
  parameter int          CW     = 5,
  parameter logic [31:0] VECTOR = 32'h5000_0150
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ex_valid,
  input logic [2:0]      ex_op,
  input logic [XLEN-1:0] ex_pc,
  input logic            trap_fire,
  input logic [1:0]      pc_sel,
  input logic [XLEN-1:0] next_pc,
  input logic            flush_if,
  input logic            flush_id,
  input logic            flush_ex,
  input logic            squash_wb,
  input logic [XLEN-1:0] epc,
  input logic [CW-1:0]   cause
);
  AST_TRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |-> (next_pc == XLEN'(VECTOR) && pc_sel == 2'd2)); // R2

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (epc == $past(ex_pc) + XLEN'(4))); // R3

  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |-> (flush_if && flush_id && flush_ex && squash_wb)); // R4

  AST_NO_STRAY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_fire |-> !(flush_if || flush_id || flush_ex || squash_wb)); // R4

  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (cause == CW'(12))); // R5

  AST_UNSIGNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && (ex_op == 3'd3 || ex_op == 3'd4)) |-> !trap_fire); // R6

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_fire |=> ($stable(epc) && $stable(cause))); // R9
endmodule

bind ovf_trap_ctrl ovf_trap_chk #(.XLEN(XLEN), .CW(CW), .VECTOR(VECTOR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ex_valid (ex_valid),
  .ex_op    (ex_op),
  .ex_pc    (ex_pc),
  .trap_fire(trap_fire),
  .pc_sel   (pc_sel),
  .next_pc  (next_pc),
  .flush_if (flush_if),
  .flush_id (flush_id),
  .flush_ex (flush_ex),
  .squash_wb(squash_wb),
  .epc      (epc),
  .cause    (cause)
);

// File: tb/tb_ovf_trap_ctrl.sv
module tb_ovf_trap_ctrl;
  localparam logic [31:0] VEC = 32'h5000_0150;

  typedef struct packed {
    logic        valid;
    logic        ovf;
    logic [2:0]  op;
    logic [31:0] pc;
    logic        br;
    logic [31:0] brt;
    logic [31:0] seq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 3'd1, 32'h0000_005C, 1'b0, 32'h0,          32'h0000_0068}, // add overflow
    '{1'b1, 1'b0, 3'd1, 32'h0000_0060, 1'b0, 32'h0,          32'h0000_006C}, // add no ovf
    '{1'b1, 1'b1, 3'd2, 32'h0000_0100, 1'b0, 32'h0,          32'h0000_010C}, // sub overflow
    '{1'b1, 1'b1, 3'd3, 32'h0000_0200, 1'b0, 32'h0,          32'h0000_020C}, // addu
    '{1'b1, 1'b1, 3'd4, 32'h0000_0204, 1'b1, 32'h0000_0400,  32'h0000_0210}, // subu + branch
    '{1'b0, 1'b1, 3'd1, 32'h0000_0208, 1'b0, 32'h0,          32'h0000_0214}, // invalid
    '{1'b1, 1'b1, 3'd0, 32'h0000_020C, 1'b0, 32'h0,          32'h0000_0218}, // nop
    '{1'b1, 1'b1, 3'd5, 32'h0000_0210, 1'b0, 32'h0,          32'h0000_021C}, // other op
    '{1'b1, 1'b1, 3'd7, 32'h0000_0214, 1'b1, 32'h0000_0800,  32'h0000_0220}, // other + branch
    '{1'b1, 1'b1, 3'd2, 32'h0000_0300, 1'b1, 32'h0000_0900,  32'h0000_030C}, // trap beats branch
    '{1'b0, 1'b0, 3'd0, 32'h0000_0304, 1'b1, 32'h0000_0A00,  32'h0000_0310}, // plain branch
    '{1'b1, 1'b1, 3'd6, 32'h0000_0308, 1'b0, 32'h0,          32'h0000_0314}  // other op
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_valid = 1'b0, ex_ovf = 1'b0, br_taken = 1'b0;
  logic [2:0]  ex_op = 3'd0;
  logic [31:0] ex_pc = '0, br_target = '0, seq_pc = '0;
  logic [1:0]  pc_sel;
  logic [31:0] next_pc, epc;
  logic        flush_if, flush_id, flush_ex, squash_wb, trap_taken;
  logic [4:0]  cause;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_epc = '0;
  logic [4:0]  m_cause = '0;

  always #5 clk = ~clk;

  ovf_trap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_op(ex_op),
    .ex_pc(ex_pc), .br_taken(br_taken), .br_target(br_target), .seq_pc(seq_pc),
    .pc_sel(pc_sel), .next_pc(next_pc), .flush_if(flush_if), .flush_id(flush_id),
    .flush_ex(flush_ex), .squash_wb(squash_wb), .trap_taken(trap_taken),
    .epc(epc), .cause(cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ex_valid = v.valid; ex_ovf = v.ovf; ex_op = v.op; ex_pc = v.pc;
    br_taken = v.br; br_target = v.brt; seq_pc = v.seq;
  endtask

  // Checks combinational outputs for the current inputs, then the registers after the edge.
  task automatic apply(input vec_t v);
    logic exp_trap;
    drive(v);
    #1;
    exp_trap = v.valid && v.ovf && (v.op == 3'd1 || v.op == 3'd2);
    chk("R1/R6 trap_taken", {31'd0, trap_taken}, {31'd0, exp_trap});
    chk("R4 flushes", {28'd0, flush_if, flush_id, flush_ex, squash_wb},
        exp_trap ? 32'hF : 32'h0);
    if (exp_trap) begin
      chk("R2/R8 next_pc", next_pc, VEC);
      chk("R2/R8 pc_sel", {30'd0, pc_sel}, 32'd2);
      m_epc = v.pc + 32'd4;
      m_cause = 5'd12;
    end else if (v.br) begin
      chk("R8 branch next_pc", next_pc, v.brt);
      chk("R8 branch pc_sel", {30'd0, pc_sel}, 32'd1);
    end else begin
      chk("R8 seq next_pc", next_pc, v.seq);
      chk("R8 seq pc_sel", {30'd0, pc_sel}, 32'd0);
    end
    @(negedge clk);
    chk("R3/R9 epc", epc, m_epc);
    chk("R5/R9 cause", {27'd0, cause}, {27'd0, m_cause});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9 reset state
    #12;
    chk("R9 reset epc", epc, 32'h0);
    chk("R9 reset cause", {27'd0, cause}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      drive('0);
      @(negedge clk);
      chk("R9 hold epc", epc, m_epc);
    end

    // Back-to-back traps: the second capture replaces the first (R3).
    apply('{1'b1, 1'b1, 3'd1, 32'h0000_1000, 1'b0, 32'h0, 32'h0});
    apply('{1'b1, 1'b1, 3'd2, 32'h0000_1004, 1'b0, 32'h0, 32'h0});
    drive('0);

    // R7 timeline: fetch from 0x50 at cycle 1; add at 0x5C (cycle 4) overflows in execute, cycle 6.
    for (int c = 1; c <= 6; c++) begin
      logic [31:0] fpc;
      fpc = 32'h50 + 32'(4 * (c - 1));
      seq_pc = fpc + 32'd4;
      if (c >= 3) begin
        ex_valid = 1'b1;
        ex_pc = fpc - 32'd8;
        ex_op = (c == 6) ? 3'd1 : 3'd2;
        ex_ovf = (c == 6);
      end
      #1;
      if (c == 6) begin
        chk("R7 handler fetched in cycle 7", next_pc, VEC);
        chk("R7 faulting pc", ex_pc, 32'h5C);
      end else if (c == 5) begin
        chk("R7 no early redirect", next_pc, 32'h64);
      end
      @(negedge clk);
    end
    drive('0);
    chk("R7 saved return address", epc, 32'h60);
    chk("R5 cause after timeline", {27'd0, cause}, 32'd12);

    // R9 async reset clears the registers again.
    rst_n = 1'b0;
    #1;
    chk("R9 reset clears epc", epc, 32'h0);
    chk("R9 reset clears cause", {27'd0, cause}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule